// File: doc/BRIEF.md
# Host Register Port with Mode-Selectable Ready Handshake

This block is the slave side of a host register port. A host reaches a small internal register bank through an active-low chip select, separate active-low read and write strobes, an address and a data bus. One output pin tells the host when the current access may end. What that pin means depends on which of three bus personalities is selected. In the two asynchronous personalities, a READY-style bus and an acknowledge-style bus, the pin is active-low. It stays high while the access is pending and returns high as soon as chip select is released. In the synchronous personality the pin is active-high, changes only on the rising clock edge, and is high for a single clock per access.

All host controls pass through two-flop synchronisers. A wait-state count, set at reset, then models the internal access latency before the pin reports completion. On a read, the bank output is presented together with a data-enable, which stays active until chip select is released. Both the personality and the wait count are static and are sampled while reset is held.

Top module: `hbus_ready_ctl`

## Requirements
- R1: While `rst` is high, `cfg_mode` and `cfg_wait` are captured. Code 00 selects the READY-style asynchronous personality, 01 the acknowledge-style asynchronous personality and 10 the synchronous personality. Code 11 behaves exactly like 00. Right after reset the pin is at its inactive level: 1 in the asynchronous personalities and 0 in the synchronous one.
- R2: An access begins only when `cs_n` is low. Strobes with `cs_n` high produce no pin activity, no data-enable and no register write.
- R3: If `cs_n` and a strobe are first sampled low at rising edge 1, the pin shows completion after rising edge `cfg_wait`+4 and not earlier.
- R4: In personality 00 the pin is 1 while idle and while the access is pending. It drives 0 on completion and holds 0 while `cs_n` stays low.
- R5: In personality 01 the pin follows the same active-low rules as in R4.
- R6: In both asynchronous personalities the pin returns to 1 in the same cycle that `cs_n` goes high, without waiting for a clock edge.
- R7: In personality 10 the pin is 0 while idle and pending. It is 1 for exactly one clock period per access, and it changes only after a rising edge.
- R8: A read drives the addressed register value on `rdata` with `rdata_oe` high, starting in the cycle in which the pin shows completion. `rdata_oe` falls in the same cycle that `cs_n` rises.
- R9: A write stores `wdata` at `addr`. A later read of that address returns it.
- R10: If both strobes are low, the access is a read and no write takes place.
- R11: Once an access has completed, no new access starts until `cs_n` has been seen high. Holding `cs_n` and the strobe low gives no second completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset, also the configuration capture window |
| cfg_mode | input | 2 | Bus personality code, captured during reset |
| cfg_wait | input | WCW | Wait-state count 0..15, captured during reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| rdata_oe | output | 1 | High while read data is valid for the host |
| rdy_pin | output | 1 | Shared ready/acknowledge pin, polarity set by personality |

## Verification
Two events can meet in one cycle. The first pair is the completion of the wait-state count and the appearance of read data with its enable, which must arrive together. The second pair, in the asynchronous personalities, is the host releasing chip select while the acknowledge is still held. The bench starts reads at random wait counts and checks `rdata`, `rdata_oe` and the pin at the exact expected edge. It then releases `cs_n` half a clock after that edge and, before any further edge, checks that both the pin and the enable have already dropped. Strobes with chip select high, reads and writes issued together, and chip select held after completion are added as directed cases.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    MODE_RDY  = 2'b00,
    MODE_ACK  = 2'b01,
    MODE_SYNC = 2'b10
  } bus_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK,
    ST_DONE
  } cyc_state_e;

  function automatic bus_mode_e decode_mode(input logic [1:0] code);
    bus_mode_e m;
    case (code)
      2'b01:   m = MODE_ACK;
      2'b10:   m = MODE_SYNC;
      default: m = MODE_RDY;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/hbus_regbank.sv
module hbus_regbank #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hbus_cycle_fsm.sv
module hbus_cycle_fsm
  import hbus_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          rd_act,
  input  logic          wr_act,
  input  logic          sync_mode,
  input  logic [CW-1:0] wait_cnt,
  output cyc_state_e    state,
  output logic          start,
  output logic          commit,
  output logic          is_rd
);

  logic [CW-1:0] cnt;

  assign start  = (state == ST_IDLE) && cs_act && (rd_act || wr_act);
  assign commit = (state == ST_WAIT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      is_rd <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cnt   <= wait_cnt;
            is_rd <= rd_act;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) state <= ST_ACK;
          else           cnt   <= cnt - 1'b1;
        end
        ST_ACK: begin
          if (sync_mode)    state <= ST_DONE;
          else if (!cs_act) state <= ST_IDLE;
        end
        default: begin
          if (!cs_act) state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/hbus_ready_ctl.sv
module hbus_ready_ctl
  import hbus_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int WCW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     cfg_mode,
  input  logic [WCW-1:0] cfg_wait,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           rdata_oe,
  output logic           rdy_pin
);

  localparam int NCTL = 3;

  bus_mode_e      mode_q;
  logic [WCW-1:0] wait_q;
  logic           sync_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= decode_mode(cfg_mode);
      wait_q <= cfg_wait;
    end
  end

  assign sync_mode = (mode_q == MODE_SYNC);

  logic [NCTL-1:0] ctl_raw, ctl_s;

  assign ctl_raw = {~cs_n, ~rd_n, ~wr_n};

  hbus_sync #(
    .W       (NCTL),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ('0)
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_s)
  );

  cyc_state_e state;
  logic       start, commit, is_rd;

  hbus_cycle_fsm #(
    .CW (WCW)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (ctl_s[2]),
    .rd_act    (ctl_s[1]),
    .wr_act    (ctl_s[0]),
    .sync_mode (sync_mode),
    .wait_cnt  (wait_q),
    .state     (state),
    .start     (start),
    .commit    (commit),
    .is_rd     (is_rd)
  );

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (start) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  hbus_regbank #(
    .AW (AW),
    .DW (DW)
  ) bank_i (
    .clk   (clk),
    .we    (commit && !is_rd),
    .waddr (addr_q),
    .wdata (wdata_q),
    .re    (start && ctl_s[1]),
    .raddr (addr),
    .rdata (rdata)
  );

  logic ack_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      ack_q <= commit || (state == ST_ACK && !sync_mode && ctl_s[2]);
      if (commit && is_rd)       oe_q <= 1'b1;
      else if (state == ST_IDLE) oe_q <= 1'b0;
    end
  end

  assign rdata_oe = oe_q && !cs_n;
  assign rdy_pin  = sync_mode ? ack_q : !(ack_q && !cs_n);

endmodule

// File: rtl/hbus_ready_ctl_chk.sv
module hbus_ready_ctl_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic rdy_pin,
  input logic rdata_oe,
  input logic sync_mode
);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sync_mode ? !rdy_pin : rdy_pin)); // R1

  AST_SYNC_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && $rose(rdy_pin)) |-> $past(!cs_n, 2)); // R2

  AST_ASYNC_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && $fell(rdy_pin)) |-> $past(!cs_n, 2)); // R2

  AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && !rdy_pin && !cs_n) |=> (!rdy_pin || cs_n)); // R4

  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && rdy_pin) |=> !rdy_pin); // R7

  AST_OE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_oe) |-> (sync_mode ? rdy_pin : !rdy_pin)); // R8

endmodule

bind hbus_ready_ctl hbus_ready_ctl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .rdy_pin   (rdy_pin),
  .rdata_oe  (rdata_oe),
  .sync_mode (sync_mode)
);

// File: tb/hbus_ready_ctl_tb_top.sv
module hbus_ready_ctl_tb_top;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int WCW = 4;
  localparam int DEPTH = 1 << AW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     cfg_mode = 2'b00;
  logic [WCW-1:0] cfg_wait = '0;
  logic           cs_n = 1'b1;
  logic           rd_n = 1'b1;
  logic           wr_n = 1'b1;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic           rdata_oe;
  logic           rdy_pin;

  always #5 clk = ~clk;

  hbus_ready_ctl #(.AW(AW), .DW(DW), .WCW(WCW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_mode (cfg_mode),
    .cfg_wait (cfg_wait),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .rdy_pin  (rdy_pin)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  int cur_mode = 0;
  int cur_wait = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_sync(input int m);
    return m == 2;
  endfunction

  function automatic bit pin_done(input int m);
    return is_sync(m) ? 1'b1 : 1'b0;
  endfunction

  function automatic bit pin_idle(input int m);
    return is_sync(m) ? 1'b0 : 1'b1;
  endfunction

  function automatic string mode_req(input int m);
    case (m)
      1: return "R5";
      2: return "R7";
      3: return "R1";
      default: return "R4";
    endcase
  endfunction

  function automatic int exp_latency(input int w);
    return w + 4;
  endfunction

  task automatic summary_and_end();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic do_reset(input int m, input int w);
    @(negedge clk);
    rst = 1'b1;
    cfg_mode = m[1:0];
    cfg_wait = w[WCW-1:0];
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur_mode = m;
    cur_wait = w;
    @(posedge clk);
    @(negedge clk);
    chk(rdy_pin == pin_idle(m), "R1", "idle pin after reset", rdy_pin, pin_idle(m));
    chk(rdata_oe == 1'b0, "R1", "data enable after reset", rdata_oe, 0);
  endtask

  // caller is at a negedge; returns at a negedge with the FSM idle again
  task automatic bus_cycle(input bit do_rd, input bit do_wr,
                           input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int hold);
    string rq;
    int lat;
    rq = mode_req(cur_mode);
    lat = exp_latency(cur_wait);
    addr = a; wdata = d;
    cs_n = 1'b0; rd_n = !do_rd; wr_n = !do_wr;
    for (int i = 1; i < lat; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == lat - 1 || i < 3)
        chk(rdy_pin == pin_idle(cur_mode), rq, "pin while pending (R3)", rdy_pin, pin_idle(cur_mode));
      if (i == lat - 1)
        chk(rdata_oe == 1'b0, "R8", "enable while pending", rdata_oe, 0);
    end
    @(posedge clk); @(negedge clk);
    chk(rdy_pin == pin_done(cur_mode), "R3", "pin at completion edge", rdy_pin, pin_done(cur_mode));
    if (do_rd) begin
      chk(rdata_oe == 1'b1, "R8", "enable at completion", rdata_oe, 1);
      chk(rdata == exp_mem[a], do_wr ? "R10" : "R9", "read data", rdata, exp_mem[a]);
    end else begin
      chk(rdata_oe == 1'b0, "R8", "enable on write", rdata_oe, 0);
      exp_mem[a] = d;
    end
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); @(negedge clk);
      if (is_sync(cur_mode))
        chk(rdy_pin == 1'b0, i == 0 ? "R7" : "R11", "pin after ready pulse", rdy_pin, 0);
      else
        chk(rdy_pin == 1'b0, rq, "acknowledge held", rdy_pin, 0);
      if (do_rd)
        chk(rdata_oe == 1'b1, "R8", "enable held with cs", rdata_oe, 1);
    end
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    #1;
    chk(rdy_pin == pin_idle(cur_mode), is_sync(cur_mode) ? "R7" : "R6",
        "pin right after cs release", rdy_pin, pin_idle(cur_mode));
    chk(rdata_oe == 1'b0, "R8", "enable right after cs release", rdata_oe, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic no_cs_strobe(input bit use_wr, input logic [AW-1:0] a,
                              input logic [DW-1:0] d);
    addr = a; wdata = d;
    cs_n = 1'b1; rd_n = use_wr; wr_n = !use_wr;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (i % 4 == 3) begin
        chk(rdy_pin == pin_idle(cur_mode), "R2", "pin with cs high", rdy_pin, pin_idle(cur_mode));
        chk(rdata_oe == 1'b0, "R2", "enable with cs high", rdata_oe, 0);
      end
    end
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary_and_end();
  end

  initial begin
    void'($urandom(32'h1c3a_77e5));

    // Fill the bank, READY-style asynchronous, no wait states
    do_reset(0, 0);
    for (int a = 0; a < DEPTH; a++)
      bus_cycle(1'b0, 1'b1, a[AW-1:0], 16'h1000 + 16'(a * 37), 1);
    bus_cycle(1'b1, 1'b0, 4'd5, '0, 2);

    // R2: strobes without chip select change nothing
    no_cs_strobe(1'b1, 4'd5, 16'hdead);
    bus_cycle(1'b1, 1'b0, 4'd5, '0, 1);
    no_cs_strobe(1'b0, 4'd6, '0);

    // R10: both strobes low is a read, no write
    bus_cycle(1'b1, 1'b1, 4'd7, 16'hbeef, 1);
    bus_cycle(1'b1, 1'b0, 4'd7, '0, 1);

    // Each personality, including the reserved code, with random wait counts
    for (int m = 0; m < 4; m++) begin
      for (int ph = 0; ph < 3; ph++) begin
        int w;
        w = (ph == 0) ? 15 : int'($urandom_range(0, 15));
        do_reset(m, w);
        for (int k = 0; k < 14; k++) begin
          bit rd;
          logic [AW-1:0] a;
          rd = $urandom_range(0, 1) == 1;
          a = AW'($urandom_range(0, DEPTH - 1));
          bus_cycle(rd, !rd, a, DW'($urandom), int'($urandom_range(1, 4)));
        end
        // R11: cs held long after completion, no second completion
        bus_cycle(1'b1, 1'b0, 4'd3, '0, 10);
        no_cs_strobe(1'b1, 4'd3, 16'h5a5a);
        bus_cycle(1'b1, 1'b0, 4'd3, '0, 1);
      end
    end

    summary_and_end();
  end

endmodule